// File: doc/BRIEF.md
# Global Trigger Decision Unit

This block makes the system-wide accept decision for a detector built from sixteen tower modules and one anticoincidence module. Each clock it reduces the tower primitive bits (tracker, calorimeter low, calorimeter high) and the anticoincidence primitive bits to a handful of summary flags. It also merges in the extra trigger sources: a commanded pulse, a random or periodic pulse, and prescaled input streams. The summary flags index a writable 32-entry table. Each table entry says whether to accept the event and which 3-bit trigger type to use.

An accepted event raises a single-cycle acknowledge that goes to all towers together with the trigger type. The same accept pushes a trigger record into a small FIFO toward the event builder. Acknowledges are held off whenever a tower reports that it has no free buffer, when the record FIFO is full, or while the dead-time window after the previous acknowledge is still running. Every cycle spent in that held-off state adds one to a dead-time counter.

Top module: `gtrig_decision_unit`

## Requirements
- R1: After reset, `ack_o` is 0, `ack_type_o` is 0, `rec_valid_o` is 0 and `dead_count_o` is 0. Every table entry reads as "no accept", so no input pattern produces an acknowledge until the table is written.
- R2: The table index is {extra, acd_any, cal_hi_any, cal_lo_any, trk_any}, with bit 0 being trk_any. Each flag is the OR of its primitive vector over all towers (or over the anticoincidence bits). The table write data is {accept in bit 3, type in bits 2:0}. A write at a clock edge affects decisions from the next edge on.
- R3: When the entry addressed at a clock edge has accept=1 and the unit is not busy, `ack_o` is 1 for exactly the following cycle and `ack_type_o` carries that entry's type. In every cycle without an acknowledge, `ack_type_o` is 0.
- R4: No acknowledge follows an edge at which any bit of `twr_throttle_i` is 1.
- R5: An acknowledge loads the dead-time window with `cfg_dead_len_i` (D). No acknowledge can follow the next D edges, so constant triggering yields one acknowledge every D+1 cycles.
- R6: `dead_count_o` increases by one for each edge at which the unit is busy, that is, throttled, FIFO full or inside the dead window. In the default variant it wraps.
- R7: Prescaler j passes the N-th, 2N-th, ... cycles in which `presc_in_i[j]` is high, where N is bits [8j+7:8j] of `cfg_presc_div_i`. N equal to 0 or 1 passes every pulse.
- R8: Each acknowledge pushes a 36-bit record {event number[35:20], type[19:17], acd_any[16], tower_fired[15:0]}. tower_fired[i] is the OR of tower i's three primitives. The event number starts at 0 after reset and increases by one per acknowledge.
- R9: The record FIFO holds 16 entries and presents its head directly on `rec_data_o` while `rec_valid_o` is 1. A word is removed at an edge where `rec_ready_i` and `rec_valid_o` are both 1. A full FIFO blocks acknowledges.
- R10: The extra flag is the OR of `cmd_trig_i`, `rand_trig_i` and all prescaler outputs. A single-cycle command or random pulse can therefore produce one acknowledge on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| twr_trk_i | input | 16 | Tracker primitive, one bit per tower |
| twr_cal_lo_i | input | 16 | Calorimeter low-threshold primitive per tower |
| twr_cal_hi_i | input | 16 | Calorimeter high-threshold primitive per tower |
| acd_prim_i | input | 8 | Anticoincidence primitive bits |
| cmd_trig_i | input | 1 | Commanded trigger pulse |
| rand_trig_i | input | 1 | Random or periodic trigger pulse |
| presc_in_i | input | 2 | Inputs to the prescalers |
| twr_throttle_i | input | 16 | Per-tower "no free buffer" flag |
| cfg_dead_len_i | input | 16 | Dead-time window length in cycles |
| cfg_presc_div_i | input | 16 | Prescale divisors, 8 bits per prescaler |
| lut_wr_en_i | input | 1 | Table write strobe |
| lut_wr_addr_i | input | 5 | Table write index |
| lut_wr_data_i | input | 4 | Table entry {accept, type} |
| rec_ready_i | input | 1 | Event builder takes the head record |
| ack_o | output | 1 | Acknowledge to all towers |
| ack_type_o | output | 3 | Trigger type sent with the acknowledge |
| dead_count_o | output | 32 | Accumulated busy cycles |
| rec_valid_o | output | 1 | Record FIFO not empty |
| rec_data_o | output | 36 | Head trigger record |

## Verification
A wrong dead-window count or a stale throttle term shows at the ports within one cycle, either as a missing acknowledge or as an extra one. The next edge then also shows it as a one-count error in `dead_count_o`. A corrupted event number or FIFO pointer only becomes visible once that record reaches the head of the FIFO. Because of that, the bench lets records pile up and then drains them. A table entry written wrongly stays hidden until its index is hit, so the bench runs a long phase of random primitives alongside directed writes to every single-flag index.

// File: rtl/gtrig_pkg.sv
package gtrig_pkg;
   localparam int unsigned TYPE_W    = 3;
   localparam int unsigned IDX_W     = 5;
   localparam int unsigned IDX_TRK   = 0;
   localparam int unsigned IDX_CALLO = 1;
   localparam int unsigned IDX_CALHI = 2;
   localparam int unsigned IDX_ACD   = 3;
   localparam int unsigned IDX_EXT   = 4;

   typedef struct packed {
      logic              accept;
      logic [TYPE_W-1:0] ttype;
   } lut_ent_t;

   localparam int unsigned ENT_W = $bits(lut_ent_t);
endpackage

// File: rtl/gtrig_prescaler.sv
module gtrig_prescaler #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_i,
   input  logic [CNT_W-1:0] div_i,
   output logic             pass_o
);
   logic [CNT_W-1:0] cnt;
   logic             last;

   assign last   = (div_i <= CNT_W'(1)) || (cnt >= div_i - CNT_W'(1));
   assign pass_o = pulse_i && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (pulse_i) begin
         cnt <= last ? '0 : cnt + CNT_W'(1);
      end
   end

   // R7: a passed pulse restarts the count
   p_pass_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |=> (cnt == '0));
   // R7: a withheld pulse advances the count by exactly one
   p_hold_advances_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && !pass_o) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/gtrig_lut.sv
module gtrig_lut
   import gtrig_pkg::*;
#(
   parameter int unsigned AW = IDX_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  lut_ent_t      wr_data_i,
   input  logic [AW-1:0] rd_idx_i,
   output lut_ent_t      rd_ent_o
);
   localparam int unsigned ENTRIES = 1 << AW;

   lut_ent_t tbl [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(ENTRIES); i++) tbl[i] <= '0;
      end else if (wr_en_i) begin
         tbl[wr_addr_i] <= wr_data_i;
      end
   end

   assign rd_ent_o = tbl[rd_idx_i];

   // R2: a write is visible on the following cycle
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && rd_idx_i == wr_addr_i) |=>
         ($past(rd_idx_i) != rd_idx_i) || (rd_ent_o == $past(wr_data_i)));
endmodule

// File: rtl/gtrig_rec_fifo.sv
module gtrig_rec_fifo #(
   parameter int unsigned WIDTH = 36,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             ready_i,
   input  logic [WIDTH-1:0] data_i,
   output logic             valid_o,
   output logic [WIDTH-1:0] data_o,
   output logic             full_o
);
   localparam int unsigned AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_chk_depth
      $error("record FIFO depth must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_ptr, wr_ptr;
   logic [AW:0]      count;
   logic             pop, push_ok;

   assign valid_o = (count != '0);
   assign full_o  = (count == (AW+1)'(DEPTH));
   assign pop     = ready_i && valid_o;
   assign push_ok = push_i && !full_o;
   assign data_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop)     rd_ptr <= rd_ptr + AW'(1);
         count <= count + (AW+1)'(push_ok) - (AW+1)'(pop);
      end
   end

   // R9: a push never arrives at a full FIFO
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R9: occupancy never exceeds the depth
   p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (AW+1)'(DEPTH));
   // R9: a pop with no push lowers occupancy by one
   p_pop_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push_i) |=> (count == $past(count) - (AW+1)'(1)));
endmodule

// File: rtl/gtrig_decision_unit.sv
module gtrig_decision_unit
   import gtrig_pkg::*;
#(
   parameter int unsigned N_TWR      = 16,
   parameter int unsigned ACD_W      = 8,
   parameter int unsigned N_PRESC    = 2,
   parameter int unsigned PRESC_W    = 8,
   parameter int unsigned DEAD_W     = 16,
   parameter int unsigned DCNT_W     = 32,
   parameter int unsigned EVNUM_W    = 16,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter bit          DCNT_SAT   = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_TWR-1:0]           twr_trk_i,
   input  logic [N_TWR-1:0]           twr_cal_lo_i,
   input  logic [N_TWR-1:0]           twr_cal_hi_i,
   input  logic [ACD_W-1:0]           acd_prim_i,
   input  logic                       cmd_trig_i,
   input  logic                       rand_trig_i,
   input  logic [N_PRESC-1:0]         presc_in_i,
   input  logic [N_TWR-1:0]           twr_throttle_i,
   input  logic [DEAD_W-1:0]          cfg_dead_len_i,
   input  logic [N_PRESC*PRESC_W-1:0] cfg_presc_div_i,
   input  logic                       lut_wr_en_i,
   input  logic [IDX_W-1:0]           lut_wr_addr_i,
   input  logic [ENT_W-1:0]           lut_wr_data_i,
   input  logic                       rec_ready_i,
   output logic                       ack_o,
   output logic [TYPE_W-1:0]          ack_type_o,
   output logic [DCNT_W-1:0]          dead_count_o,
   output logic                       rec_valid_o,
   output logic [EVNUM_W+TYPE_W+1+N_TWR-1:0] rec_data_o
);
   localparam int unsigned REC_W = EVNUM_W + TYPE_W + 1 + N_TWR;

   if (N_TWR < 1 || N_PRESC < 1 || ACD_W < 1) begin : g_chk_counts
      $error("source counts must be at least one");
   end
   if (DEAD_W > DCNT_W) begin : g_chk_widths
      $error("dead counter must be at least as wide as the window");
   end

   // primitive reduction
   logic [N_TWR-1:0] tower_fired;
   for (genvar t = 0; t < int'(N_TWR); t++) begin : g_twr
      assign tower_fired[t] = twr_trk_i[t] | twr_cal_lo_i[t] | twr_cal_hi_i[t];
   end

   logic [N_PRESC-1:0] presc_pass;
   for (genvar p = 0; p < int'(N_PRESC); p++) begin : g_presc
      gtrig_prescaler #(.CNT_W(PRESC_W)) u_presc (
         .clk     (clk),
         .rst_n   (rst_n),
         .pulse_i (presc_in_i[p]),
         .div_i   (cfg_presc_div_i[p*PRESC_W +: PRESC_W]),
         .pass_o  (presc_pass[p])
      );
   end

   logic acd_any, extra_any;
   logic [IDX_W-1:0] lut_idx;
   assign acd_any   = |acd_prim_i;
   assign extra_any = cmd_trig_i | rand_trig_i | (|presc_pass);

   always_comb begin
      lut_idx            = '0;
      lut_idx[IDX_TRK]   = |twr_trk_i;
      lut_idx[IDX_CALLO] = |twr_cal_lo_i;
      lut_idx[IDX_CALHI] = |twr_cal_hi_i;
      lut_idx[IDX_ACD]   = acd_any;
      lut_idx[IDX_EXT]   = extra_any;
   end

   lut_ent_t ent;
   gtrig_lut #(.AW(IDX_W)) u_lut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (lut_wr_en_i),
      .wr_addr_i (lut_wr_addr_i),
      .wr_data_i (lut_ent_t'(lut_wr_data_i)),
      .rd_idx_i  (lut_idx),
      .rd_ent_o  (ent)
   );

   // gating and acknowledge
   logic              fifo_full, busy, accept;
   logic [DEAD_W-1:0] dead_cnt;
   logic [EVNUM_W-1:0] ev_num;
   logic [REC_W-1:0]  rec_in;

   assign busy   = (|twr_throttle_i) || fifo_full || (dead_cnt != '0);
   assign accept = ent.accept && !busy;
   assign rec_in = {ev_num, ent.ttype, acd_any, tower_fired};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_o      <= 1'b0;
         ack_type_o <= '0;
         dead_cnt   <= '0;
         ev_num     <= '0;
      end else begin
         ack_o      <= accept;
         ack_type_o <= accept ? ent.ttype : '0;
         if (accept) begin
            dead_cnt <= cfg_dead_len_i;
            ev_num   <= ev_num + EVNUM_W'(1);
         end else if (dead_cnt != '0) begin
            dead_cnt <= dead_cnt - DEAD_W'(1);
         end
      end
   end

   // dead-time accumulation: wrapping or saturating variant
   if (DCNT_SAT) begin : g_dcnt_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                        dead_count_o <= '0;
         else if (busy && !(&dead_count_o)) dead_count_o <= dead_count_o + DCNT_W'(1);
      end
   end else begin : g_dcnt_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)    dead_count_o <= '0;
         else if (busy) dead_count_o <= dead_count_o + DCNT_W'(1);
      end
      // R6: every busy cycle adds exactly one
      p_busy_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
         busy |=> (dead_count_o == $past(dead_count_o) + DCNT_W'(1)));
   end

   gtrig_rec_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (accept),
      .ready_i (rec_ready_i),
      .data_i  (rec_in),
      .valid_o (rec_valid_o),
      .data_o  (rec_data_o),
      .full_o  (fifo_full)
   );

   // R4: a throttled edge is never followed by an acknowledge
   p_throttle_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|twr_throttle_i) |=> !ack_o);
   // R5: an acknowledge opens a window of the configured length
   p_dead_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (dead_cnt == $past(cfg_dead_len_i)));
   // R5: no acknowledge while the window runs
   p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dead_cnt != '0) |=> !ack_o);
   // R8: event number steps once per acknowledge
   p_evnum_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (ev_num == $past(ev_num) + EVNUM_W'(1)));
   // R3: acknowledge lasts one cycle when a window follows it
   p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && dead_cnt != '0) |=> !ack_o);
endmodule

// File: tb/gtrig_decision_unit_tb_top.sv
`timescale 1ns/1ps
module gtrig_decision_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] trk = '0, callo = '0, calhi = '0, thr = '0;
   logic [7:0]  acd = '0;
   logic        cmd = 1'b0, rnd = 1'b0, ready = 1'b1;
   logic [1:0]  pin = '0;
   logic [15:0] dead_len = '0;
   logic [15:0] pdiv = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [3:0]  wr_data = '0;
   logic        ack;
   logic [2:0]  ack_type;
   logic [31:0] dcount;
   logic        rvalid;
   logic [35:0] rdata;

   int checks = 0, fails = 0, acks_seen = 0;

   always #2.5 clk = ~clk;

   gtrig_decision_unit dut_i (
      .clk(clk), .rst_n(rst_n), .twr_trk_i(trk), .twr_cal_lo_i(callo),
      .twr_cal_hi_i(calhi), .acd_prim_i(acd), .cmd_trig_i(cmd),
      .rand_trig_i(rnd), .presc_in_i(pin), .twr_throttle_i(thr),
      .cfg_dead_len_i(dead_len), .cfg_presc_div_i(pdiv),
      .lut_wr_en_i(wr_en), .lut_wr_addr_i(wr_addr), .lut_wr_data_i(wr_data),
      .rec_ready_i(ready), .ack_o(ack), .ack_type_o(ack_type),
      .dead_count_o(dcount), .rec_valid_o(rvalid), .rec_data_o(rdata)
   );

   // behavioural reference model
   int          m_lut [32];
   int          m_dead;
   int          m_pc [2];
   logic [31:0] m_dc;
   logic [15:0] m_ev;
   logic        m_ack;
   logic [2:0]  m_type;
   logic [35:0] m_q [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_lut[i]) m_lut[i] = 0;
         m_dead = 0; m_pc[0] = 0; m_pc[1] = 0;
         m_dc = 0; m_ev = 0; m_ack = 0; m_type = 0;
         m_q.delete();
      end else begin
         bit ext, busy, acc;
         int idx, ent, div;
         logic [15:0] fired;
         ext = cmd | rnd;
         for (int j = 0; j < 2; j++) begin
            div = int'(pdiv[j*8 +: 8]);
            if (pin[j]) begin
               if (div <= 1 || m_pc[j] >= div - 1) begin
                  ext = 1; m_pc[j] = 0;
               end else m_pc[j] = m_pc[j] + 1;
            end
         end
         idx = (|trk ? 1 : 0) + (|callo ? 2 : 0) + (|calhi ? 4 : 0)
             + (|acd ? 8 : 0) + (ext ? 16 : 0);
         ent = m_lut[idx];
         busy = (thr != 0) || (m_q.size() == 16) || (m_dead != 0);
         acc = ent[3] && !busy;
         fired = trk | callo | calhi;
         if (ready && m_q.size() > 0) void'(m_q.pop_front());
         if (busy) m_dc = m_dc + 1;
         if (acc) begin
            m_q.push_back({m_ev, 3'(ent), |acd, fired});
            m_ev = m_ev + 1;
            m_dead = int'(dead_len);
            m_ack = 1; m_type = 3'(ent);
         end else begin
            m_ack = 0; m_type = 0;
            if (m_dead > 0) m_dead = m_dead - 1;
         end
         if (wr_en) m_lut[wr_addr] = int'(wr_data);
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R3 ack", 64'(ack), 64'(m_ack));
      chk("R2 type", 64'(ack_type), 64'(m_type));
      chk("R6 dead_count", 64'(dcount), 64'(m_dc));
      chk("R9 valid", 64'(rvalid), 64'(m_q.size() > 0));
      if (m_q.size() > 0) chk("R8 record", 64'(rdata), 64'(m_q[0]));
      if (ack) acks_seen++;
   endtask

   task automatic tick(int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
         compare_all();
      end
   endtask

   task automatic lut_write(int addr, bit acc, int typ);
      wr_en = 1; wr_addr = 5'(addr); wr_data = {acc, 3'(typ)};
      tick(1);
      wr_en = 0;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ack", 64'(ack), 0);
      chk("R1 valid", 64'(rvalid), 0);
      chk("R1 dead_count", 64'(dcount), 0);
      chk("R1 type", 64'(ack_type), 0);
      rst_n = 1;
      // R1: empty table accepts nothing
      trk = 16'h0001; calhi = 16'h0100; acd = 8'h01; cmd = 1;
      acks_seen = 0; tick(5);
      chk("R1 no accept before table write", 64'(acks_seen), 0);
      trk = 0; calhi = 0; acd = 0; cmd = 0;

      // R5: dead window spacing
      lut_write(1, 1, 5);
      dead_len = 3; trk = 16'h0010; acks_seen = 0;
      tick(20);
      chk("R5 acks with window 3 over 20 cycles", 64'(acks_seen), 5);
      trk = 0; tick(5);

      // R4: throttle blocks
      thr = 16'h0080; trk = 16'h8000; acks_seen = 0;
      tick(10);
      chk("R4 acks under throttle", 64'(acks_seen), 0);
      thr = 0; trk = 0; tick(2);

      // R9: FIFO fill blocks acknowledges
      dead_len = 0; ready = 0; tick(20);
      trk = 16'h0003; acks_seen = 0;
      tick(30);
      chk("R9 acks until FIFO full", 64'(acks_seen), 16);
      trk = 0; ready = 1; tick(20);
      chk("R9 FIFO drained", 64'(rvalid), 0);

      // R7: prescaler
      lut_write(16, 1, 2);
      pdiv = 16'h0003; pin = 2'b01; acks_seen = 0;
      tick(9);
      chk("R7 one of three prescaled pulses", 64'(acks_seen), 3);
      pin = 2'b10; acks_seen = 0;
      tick(4);
      chk("R7 divisor 0 passes all", 64'(acks_seen), 4);
      pin = 0; tick(2);

      // R10: single command and random pulses
      cmd = 1; acks_seen = 0; tick(1); cmd = 0; tick(3);
      chk("R10 command pulse", 64'(acks_seen), 1);
      rnd = 1; acks_seen = 0; tick(1); rnd = 0; tick(3);
      chk("R10 random pulse", 64'(acks_seen), 1);

      // R2: single-flag indices with distinct types
      lut_write(2, 1, 3); lut_write(4, 1, 6); lut_write(8, 1, 7);
      lut_write(12, 1, 1);
      callo = 16'h0400; tick(2); callo = 0; tick(1);
      calhi = 16'h0002; tick(2); calhi = 0; tick(1);
      acd = 8'h40; tick(2); acd = 0; tick(1);
      acd = 8'h01; calhi = 16'h4000; tick(2); acd = 0; calhi = 0; tick(2);

      // mixed random phase, every cycle compared with the model
      dead_len = 2; pdiv = 16'h0402;
      for (int c = 0; c < 3000; c++) begin
         trk   = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : '0;
         callo = ($urandom % 5 == 0) ? 16'(1 << ($urandom % 16)) : '0;
         calhi = ($urandom % 7 == 0) ? 16'(1 << ($urandom % 16)) : '0;
         acd   = ($urandom % 6 == 0) ? 8'(1 << ($urandom % 8)) : '0;
         cmd   = ($urandom % 20 == 0);
         rnd   = ($urandom % 20 == 0);
         pin   = 2'($urandom);
         thr   = ($urandom % 10 == 0) ? 16'(1 << ($urandom % 16)) : '0;
         ready = ($urandom % 3 != 0);
         wr_en = ($urandom % 8 == 0);
         wr_addr = 5'($urandom); wr_data = 4'($urandom);
         tick(1);
      end
      wr_en = 0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule